// File: doc/BRIEF.md
# Selectable-Length Register-Exchange Viterbi Decoder

This block decodes hard-decision symbols of a rate 1/2 convolutional code. Each input beat carries one received coded pair, and each trellis step yields one decoded bit. The constraint length is chosen per packet from three options (5, 7, 9), which gives 16, 64 or 256 live trellis states. Every live state has its own add-compare-select unit. All of them update in the same clock cycle. Each state keeps its whole decoded history in a survivor register that is copied from the winning predecessor on every step, so the block needs no traceback pass.

A packet holds 64 information bits followed by K-1 zero tail bits, so it has 64+K-1 input beats. When the last beat has been taken, the survivor of state zero is streamed out one bit per handshake, oldest information bit first, and the tail bits are dropped. State units above the live count for the current packet keep their contents and do not toggle.

The controller has three states:
- `S_IDLE` accepts beats. A beat with the start strobe latches the length code, seeds the metrics and makes the first trellis step. It moves to `S_RUN`.
- `S_RUN` makes one trellis step per accepted beat. When the final beat of the packet is taken, it moves to `S_EMIT`.
- `S_EMIT` drops input ready and emits 64 bits. When the marked last bit is accepted, it returns to `S_IDLE`.

Top module: `vit_re_decoder`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: Length code 0 selects K=5 with generators 10011b/11101b. Code 1 selects K=7 with 1111001b/1011011b. Code 2 selects K=9 with 111101011b/101110001b. Code 3 behaves as code 2.
- R3: Encoding convention. The encoder register is {current bit, previous bits}, and each generator's MSB taps the current bit. `in_sym[1]` is the parity from the first generator and `in_sym[0]` is the parity from the second.
- R4: Seeding. `in_klen` is sampled only on a start beat in `S_IDLE`. Beats taken in `S_IDLE` without `in_sop` are dropped, and `in_sop` during `S_RUN` is treated as plain data.
- R5: With error-free input, the 64 decoded bits equal the encoded information bits for every length code.
- R6: Metrics. Branch metrics are Hamming distances, path metrics are 8-bit saturating, and the minimum live metric is subtracted whenever a live metric has its top bit set. With this, isolated symbol-bit errors are corrected.
- R7: After 64+K-1 accepted beats, exactly 64 bits are emitted, first information bit first. `out_last` is 1 only on the 64th bit.
- R8: While `out_valid` is 1, `in_ready` is 0. A new packet can start only after the last output bit has been accepted.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_bit` and `out_last` hold their values.
- R10: State units at or above 2^(K-1) hold their metric and survivor during a packet. Packets of different lengths can follow each other back to back with no other setup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Decoder can take a beat |
| in_sym | input | 2 | Received coded pair (bit1 from first generator) |
| in_sop | input | 1 | First beat of a packet |
| in_klen | input | 2 | Constraint-length code, sampled with `in_sop` |
| out_valid | output | 1 | Decoded bit valid |
| out_ready | input | 1 | Sink takes the decoded bit |
| out_bit | output | 1 | Decoded information bit |
| out_last | output | 1 | Marks the 64th bit of a packet |

## Verification
The bench builds the block with its default parameters: 64-bit packets and 8-bit metrics. Under these defaults all three lengths fit, including the full 256-state array. Every code therefore decodes its full tail and runs long enough for the metrics to saturate and for normalisation to act. The scenarios cover:
- packets of mixed lengths sent back to back, so that units left idle by a short packet are run again after a long one;
- symbol-bit flips spaced out within a packet;
- gaps in the input valid stream and stalls on the output ready signal;
- stray beats taken in the idle state.

// File: rtl/vit_pkg.sv
package vit_pkg;
    localparam int KMAX = 9;

    function automatic int klen_of(input logic [1:0] code);
        unique case (code)
            2'd0:    return 5;
            2'd1:    return 7;
            default: return 9;
        endcase
    endfunction

    function automatic logic [KMAX-1:0] gen_a(input logic [1:0] code);
        unique case (code)
            2'd0:    return 9'b000010011;
            2'd1:    return 9'b001111001;
            default: return 9'b111101011;
        endcase
    endfunction

    function automatic logic [KMAX-1:0] gen_b(input logic [1:0] code);
        unique case (code)
            2'd0:    return 9'b000011101;
            2'd1:    return 9'b001011011;
            default: return 9'b101110001;
        endcase
    endfunction
endpackage

// File: rtl/vit_state_unit.sv
module vit_state_unit #(
    parameter int MW = 8,
    parameter int SW = 72
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [MW-1:0] pm_a,
    input  logic [MW-1:0] pm_b,
    input  logic [MW-1:0] sub,
    input  logic [1:0]    bm_a,
    input  logic [1:0]    bm_b,
    input  logic [SW-1:0] sv_a,
    input  logic [SW-1:0] sv_b,
    input  logic          dbit,
    output logic [MW-1:0] pm_q,
    output logic [SW-1:0] sv_q
);
    logic [MW:0]   ca, cb, cw;
    logic          pick_b;
    logic [MW-1:0] pm_d;
    logic [SW-1:0] sv_d;

    always_comb begin
        ca     = (MW+1)'(pm_a - sub) + (MW+1)'(bm_a);
        cb     = (MW+1)'(pm_b - sub) + (MW+1)'(bm_b);
        pick_b = cb < ca;
        cw     = pick_b ? cb : ca;
        pm_d   = cw[MW] ? {MW{1'b1}} : cw[MW-1:0];
        sv_d   = pick_b ? {sv_b[SW-2:0], dbit} : {sv_a[SW-2:0], dbit};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pm_q <= '0;
            sv_q <= '0;
        end else if (en) begin
            pm_q <= pm_d;
            sv_q <= sv_d;
        end
    end
endmodule

// File: rtl/vit_re_decoder.sv
module vit_re_decoder #(
    parameter int PKT_BITS = 64,
    parameter int MW       = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [1:0] in_sym,
    input  logic       in_sop,
    input  logic [1:0] in_klen,
    output logic       out_valid,
    input  logic       out_ready,
    output logic       out_bit,
    output logic       out_last
);
    import vit_pkg::*;

    localparam int NS = 1 << (KMAX - 1);
    localparam int SW = PKT_BITS + KMAX - 1;
    localparam int CW = $clog2(SW + 1);
    localparam int EW = $clog2(PKT_BITS);

    typedef enum logic [1:0] {S_IDLE, S_RUN, S_EMIT} st_t;
    st_t st_q, st_d;

    logic [1:0]    kc_q, kc_eff;
    logic [CW-1:0] cnt_q;
    logic [EW-1:0] ecnt_q;
    logic          acc, start, step, last_in, out_fire;
    int            klen, nact, nbeats;
    logic [KMAX-1:0] ga, gb;
    logic [MW-1:0] pm [NS];
    logic [SW-1:0] sv [NS];
    logic [MW-1:0] mn, sub;
    logic          big;

    always_comb begin
        acc      = in_valid && in_ready;
        start    = acc && (st_q == S_IDLE) && in_sop;
        step     = start || (acc && (st_q == S_RUN));
        kc_eff   = start ? in_klen : kc_q;
        klen     = klen_of(kc_eff);
        nact     = 1 << (klen - 1);
        nbeats   = PKT_BITS + klen - 1;
        ga       = gen_a(kc_eff);
        gb       = gen_b(kc_eff);
        last_in  = acc && (st_q == S_RUN) && (int'(cnt_q) == nbeats - 1);
        out_fire = out_valid && out_ready;
    end

    // Normalisation: minimum over live states, applied when a live metric is past half range
    always_comb begin
        mn  = {MW{1'b1}};
        big = 1'b0;
        for (int s = 0; s < NS; s++) begin
            if (s < nact) begin
                if (pm[s] < mn) mn = pm[s];
                if (pm[s][MW-1]) big = 1'b1;
            end
        end
        sub = (start || !big) ? '0 : mn;
    end

    for (genvar s = 0; s < NS; s++) begin : g_state
        logic [MW-1:0] pma, pmb;
        logic [SW-1:0] sva, svb;
        logic [1:0]    bma, bmb;
        logic          dbit, en;

        always_comb begin
            int pa, pb;
            logic [KMAX-1:0] ra, rb;
            pa   = (s << 1) & (nact - 1);
            pb   = pa | 1;
            dbit = ((s >> (klen - 2)) & 1) != 0;
            ra   = KMAX'((int'(dbit) << (klen - 1)) | pa);
            rb   = KMAX'((int'(dbit) << (klen - 1)) | pb);
            bma  = 2'((in_sym[1] ^ (^(ra & ga)))) + 2'((in_sym[0] ^ (^(ra & gb))));
            bmb  = 2'((in_sym[1] ^ (^(rb & ga)))) + 2'((in_sym[0] ^ (^(rb & gb))));
            pma  = start ? ((pa == 0) ? '0 : {MW{1'b1}}) : pm[pa];
            pmb  = start ? {MW{1'b1}} : pm[pb];
            sva  = start ? '0 : sv[pa];
            svb  = start ? '0 : sv[pb];
            en   = step && (s < nact);
        end

        vit_state_unit #(.MW(MW), .SW(SW)) u_unit (
            .clk(clk), .rst_n(rst_n), .en(en),
            .pm_a(pma), .pm_b(pmb), .sub(sub),
            .bm_a(bma), .bm_b(bmb), .sv_a(sva), .sv_b(svb),
            .dbit(dbit), .pm_q(pm[s]), .sv_q(sv[s])
        );
    end

    // State register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= S_IDLE;
            kc_q   <= '0;
            cnt_q  <= '0;
            ecnt_q <= '0;
        end else begin
            st_q <= st_d;
            if (start) begin
                kc_q  <= in_klen;
                cnt_q <= CW'(1);
            end else if (acc && st_q == S_RUN) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (st_q != S_EMIT)  ecnt_q <= '0;
            else if (out_fire)   ecnt_q <= ecnt_q + 1'b1;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE: if (start)                st_d = S_RUN;
            S_RUN:  if (last_in)              st_d = S_EMIT;
            S_EMIT: if (out_fire && out_last) st_d = S_IDLE;
            default:                          st_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        in_ready  = (st_q != S_EMIT);
        out_valid = (st_q == S_EMIT);
        out_last  = out_valid && (int'(ecnt_q) == PKT_BITS - 1);
        out_bit   = out_valid && sv[0][nbeats - 1 - int'(ecnt_q)];
    end

    // R8
    busy_no_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);
    // R7
    last_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);
    // R7
    emit_after_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_in |=> (out_valid && !out_last));
    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_bit) && $stable(out_last)));
    // R10
    idle_unit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_RUN && kc_q != 2'd2 && kc_q != 2'd3) |=> ($stable(pm[NS-1]) && $stable(sv[NS-1])));
endmodule

// File: tb/tb_vit_re_decoder.sv
module tb_vit_re_decoder;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst_n = 0;
    logic in_valid = 0, in_sop = 0, out_ready = 0;
    logic [1:0] in_sym = 0, in_klen = 0;
    logic in_ready, out_valid, out_bit, out_last;
    int checks = 0, fails = 0, cyc = 0;

    vit_re_decoder dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_sym(in_sym), .in_sop(in_sop), .in_klen(in_klen),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_bit(out_bit), .out_last(out_last)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: act=hung exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic put(input logic [1:0] sym, input logic sop, input logic [1:0] kc);
        in_valid = 1; in_sym = sym; in_sop = sop; in_klen = kc;
        forever begin
            if (in_ready) begin
                @(negedge clk);
                break;
            end
            @(negedge clk);
        end
        in_valid = 0; in_sop = 0;
    endtask

    // R2 R3: independent encoder, taps with generator MSB on the current bit
    task automatic run_packet(input logic [1:0] kc, input logic [63:0] data,
                              input int flip_a, input int flip_b, input int mode,
                              input string tag);
        int k, nb, n;
        logic [8:0] ga, gb, sr;
        logic [63:0] got, lastpos;
        logic ready_seen;
        k  = (kc == 0) ? 5 : (kc == 1) ? 7 : 9;
        ga = (kc == 0) ? 9'o023 : (kc == 1) ? 9'o171 : 9'o753;
        gb = (kc == 0) ? 9'o035 : (kc == 1) ? 9'o133 : 9'o561;
        nb = 64 + k - 1;
        sr = 0;
        for (int i = 0; i < nb; i++) begin
            logic u;
            logic [1:0] sym;
            u   = (i < 64) ? data[i] : 1'b0;
            sr  = 9'((int'(u) << (k - 1)) | int'(sr >> 1));
            sym = {^(sr & ga), ^(sr & gb)};
            if (i == flip_a) sym ^= 2'b01;
            if (i == flip_b) sym ^= 2'b10;
            if ((mode & 1) && (i % 5 == 3)) @(negedge clk);
            put(sym, i == 0, kc);
        end
        n = 0; got = 0; lastpos = 0; ready_seen = 0;
        while (n < 64) begin
            out_ready = (mode & 2) ? ((cyc % 3) != 0) : 1'b1;
            #1;
            if (out_valid && in_ready) ready_seen = 1;
            if (out_valid && out_ready) begin
                got[n] = out_bit;
                lastpos[n] = out_last;
                n++;
            end
            @(negedge clk);
        end
        out_ready = 0;
        check({"R5/R6 data ", tag}, got, data);
        check({"R7 last marker ", tag}, lastpos, 64'h8000_0000_0000_0000);
        check({"R8 ready low in emit ", tag}, 64'(ready_seen), 64'd0);
        #1;
        check({"R7 no extra output ", tag}, 64'(out_valid), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1
        check("R1 in_ready reset", 64'(in_ready), 64'd1);
        check("R1 out_valid reset", 64'(out_valid), 64'd0);
        rst_n = 1;
        @(negedge clk);
        // R5 clean packets for each code
        run_packet(2'd0, 64'hA5C3_0F1E_9B27_44D1, -1, -1, 0, "K5 clean");
        run_packet(2'd1, 64'h1234_5678_9ABC_DEF0, -1, -1, 1, "K7 clean gaps");
        run_packet(2'd2, 64'hFEDC_BA98_7654_3210, -1, -1, 2, "K9 clean stalls");
        // R10 short packet right after the long one
        run_packet(2'd0, 64'h0F0F_3C3C_5555_AAAA, -1, -1, 0, "R10 K5 after K9");
        // R6 isolated errors
        run_packet(2'd0, 64'hDEAD_BEEF_CAFE_F00D, 10, 40, 0, "R6 K5 errors");
        run_packet(2'd2, 64'h0123_4567_89AB_CDEF, 5, 45, 3, "R6 K9 errors");
        // R4 stray beats in idle are dropped, sop in run is data
        put(2'b11, 1'b0, 2'd2);
        put(2'b10, 1'b0, 2'd2);
        check("R4 idle stray ready", 64'(in_ready), 64'd1);
        run_packet(2'd1, 64'h8000_0000_0000_0001, 20, -1, 0, "R4 K7 after stray");
        // R2 code 3 acts as K=9
        run_packet(2'd3, 64'h7777_0000_FFFF_1111, -1, -1, 0, "R2 code3");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule